// File: doc/BRIEF.md
# Single-Wire Parity Chunk Codec

This block moves one short chunk of 1 to 8 bits across a single shared data line. It either transmits or receives, depending on a mode input sampled with the start strobe. A chunk is a run of data bit cells, most significant bit first, followed by one even-parity cell. Every cell lasts a programmable number of clock cycles, and the period and chunk width are captured when a start strobe is accepted. Eight-bit chunks suit data bytes, and seven-bit chunks suit a short identifier word.

When transmitting, the codec drives a line value and a drive-enable. After the parity cell it keeps driving the line low, so that whatever protocol step comes next starts from a known low level and can detect a rising edge. When receiving, it releases the line and passes the line input through a two-flop synchronizer. It samples each cell near its middle, after the first floor(P/2) cycles of a P-cycle cell. It then reports the right-aligned data, a parity-mismatch flag and a saturating count of mismatches.

The line direction between chunks, the handshakes that separate chunks, and any byte buffering belong to the surrounding logic.

Top module: `swire_chunk_codec`

## Requirements
- R1: Right after reset, lineOut, lineOe, busy, done, parityErr, rxData and errCount are all 0.
- R2: A transmit chunk puts its first cell on lineOut in the cycle after the start is accepted, with lineOe high. Data bit width-1 goes first, then the bits downward to bit 0. Each cell lasts exactly bitPeriod cycles.
- R3: The cell after the last data bit carries even parity, which is the XOR of the data bits sent.
- R4: When the parity cell of a transmit chunk ends, lineOut goes to 0 while lineOe stays 1. Both hold until the next accepted start. done rises exactly (width+1)*bitPeriod cycles after the accepting edge.
- R5: A receive chunk releases lineOe. Cell k is taken to begin on the raw line k*bitPeriod cycles after the accepting edge. rxData holds the received bits right-aligned, with the first received bit as the most significant of the low width bits and all upper bits 0. rxData is valid with done, which rises (width+1)*bitPeriod+2 cycles after the accepting edge.
- R6: parityErr is 1 when the received parity cell differs from the XOR of the received data bits. It is updated only when a receive chunk completes.
- R7: errCount adds one for each receive chunk with a parity mismatch and saturates at its all-ones value.
- R8: While busy is high a start strobe is ignored, whatever the mode input.
- R9: A width of 0 or above 8 is taken as 8. bitPeriod and width are captured at the accepted start, so later changes have no effect on that chunk.
- R10: done is a one-cycle pulse and busy is low in that cycle, so a new start can be accepted there.
- R11: The receive sample point is floor(bitPeriod/2) raw cycles into a cell, for odd and even periods alike. The value on the line outside that instant has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when busy is low |
| txMode | input | 1 | 1 = transmit chunk, 0 = receive chunk, sampled with start |
| chunkWidth | input | 4 | Data bits per chunk, 1 to 8 |
| bitPeriod | input | 8 | Clock cycles per bit cell, 4 or more |
| txData | input | 8 | Data to send, low width bits used |
| lineIn | input | 1 | Line level, asynchronous |
| lineOut | output | 1 | Value driven onto the line |
| lineOe | output | 1 | Drive enable for the line |
| rxData | output | 8 | Received chunk, right-aligned |
| parityErr | output | 1 | Parity mismatch of the last received chunk |
| errCount | output | 4 | Saturating count of parity mismatches |
| busy | output | 1 | Chunk in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A cell counter that is off by one shows up on lineOut within the first cell as a transition one cycle early or late. It also moves the done pulse by one cycle for every cell in the chunk. A sample point placed wrongly is exposed by a receive stimulus that holds the correct level only during the single raw cycle the codec should sample; every other cycle carries the inverted bit, so rxData and parityErr come out wrong in the same chunk. A bad parity accumulator or a bad counter update appears at the next done pulse, and a mishandled saturation appears once the count reaches its all-ones value.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX_LAT,
    ST_TX_CELL,
    ST_RX_CELL
  } codecState_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic loadTx;   // accepted transmit start
    logic loadRx;   // accepted receive start
    logic txNext;   // move to next data cell
    logic txPar;    // move to the parity cell
    logic txEnd;    // parity cell finished, enter low tail
    logic rxBit;    // sample point of a data cell
    logic rxPar;    // sample point of the parity cell
    logic rxEnd;    // last receive cell finished
  } strobe_t;

endpackage

// File: rtl/swc_ctrl.sv
module swc_ctrl #(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 8,
  parameter int WID_W    = 4,
  parameter int SYNC_LAT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                txMode,
  input  logic [WID_W-1:0]    chunkWidth,
  input  logic [PERIOD_W-1:0] bitPeriod,
  output swc_pkg::strobe_t    strobes,
  output logic [WID_W-1:0]    effLen,
  output logic                busy
);
  import swc_pkg::*;

  localparam int LAT_W = $clog2(SYNC_LAT + 1);
  localparam logic [LAT_W-1:0]    LAT_LAST  = LAT_W'(SYNC_LAT - 1);
  localparam logic [WID_W-1:0]    FULL_LEN  = WID_W'(DATA_W);
  localparam logic [WID_W-1:0]    LEN_ZERO  = '0;
  localparam logic [WID_W-1:0]    LEN_ONE   = WID_W'(1);
  localparam logic [PERIOD_W-1:0] PER_ONE   = PERIOD_W'(1);
  localparam logic [PERIOD_W-1:0] PER_RESET = PERIOD_W'(4);

  codecState_t         state;
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] perReg;
  logic [WID_W-1:0]    cellIdx;
  logic [LAT_W-1:0]    latCnt;

  logic startAcc;
  logic cellEnd;
  logic sampleHit;

  // out-of-range widths fall back to the full data width
  always_comb begin
    if (chunkWidth == LEN_ZERO || chunkWidth > FULL_LEN) effLen = FULL_LEN;
    else                                                 effLen = chunkWidth;
  end

  assign startAcc  = start && (state == ST_IDLE);
  assign cellEnd   = (cnt == perReg - PER_ONE);
  assign sampleHit = (cnt == (perReg >> 1) - PER_ONE);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobes        = '0;
    strobes.loadTx = startAcc && txMode;
    strobes.loadRx = startAcc && !txMode;
    if (state == ST_TX_CELL && cellEnd) begin
      if (cellIdx > LEN_ONE)       strobes.txNext = 1'b1;
      else if (cellIdx == LEN_ONE) strobes.txPar  = 1'b1;
      else                         strobes.txEnd  = 1'b1;
    end
    if (state == ST_RX_CELL) begin
      if (sampleHit) begin
        if (cellIdx != LEN_ZERO) strobes.rxBit = 1'b1;
        else                     strobes.rxPar = 1'b1;
      end
      if (cellEnd && cellIdx == LEN_ZERO) strobes.rxEnd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      perReg  <= PER_RESET;
      cellIdx <= '0;
      latCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startAcc) begin
            perReg  <= bitPeriod;
            cellIdx <= effLen;
            cnt     <= '0;
            latCnt  <= '0;
            state   <= txMode ? ST_TX_CELL : ST_RX_LAT;
          end
        end
        ST_RX_LAT: begin
          // shift the receive cell grid by the synchronizer latency
          if (latCnt == LAT_LAST) begin
            state <= ST_RX_CELL;
            cnt   <= '0;
          end else begin
            latCnt <= latCnt + 1'b1;
          end
        end
        ST_TX_CELL, ST_RX_CELL: begin
          if (cellEnd) begin
            cnt <= '0;
            if (cellIdx == LEN_ZERO) state <= ST_IDLE;
            else                     cellIdx <= cellIdx - LEN_ONE;
          end else begin
            cnt <= cnt + PER_ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swc_dpath.sv
module swc_dpath #(
  parameter int DATA_W   = 8,
  parameter int WID_W    = 4,
  parameter int ERR_W    = 4,
  parameter int SYNC_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  swc_pkg::strobe_t  strobes,
  input  logic [WID_W-1:0]  effLen,
  input  logic [DATA_W-1:0] txData,
  input  logic              lineIn,
  output logic              lineOut,
  output logic              lineOe,
  output logic [DATA_W-1:0] rxData,
  output logic              parityErr,
  output logic [ERR_W-1:0]  errCount,
  output logic              done
);
  localparam logic [WID_W-1:0] FULL_LEN = WID_W'(DATA_W);
  localparam logic [ERR_W-1:0] ERR_MAX  = '1;

  logic [SYNC_LAT-1:0] syncPipe;
  logic                lineSync;

  logic [DATA_W-1:0] aligned;
  logic              txParCalc;
  logic [DATA_W-1:0] txShift;
  logic              txParBit;

  logic [DATA_W-1:0] rxShift;
  logic              rxAcc;
  logic              rxParSeen;
  logic              rxMismatch;

  // input synchronizer, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '1;
    else       syncPipe <= {syncPipe[SYNC_LAT-2:0], lineIn};
  end
  assign lineSync = syncPipe[SYNC_LAT-1];

  // left-align the chunk so its top bit sits at the MSB, and build even parity
  always_comb begin
    aligned   = txData << (FULL_LEN - effLen);
    txParCalc = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (WID_W'(i) < effLen) txParCalc = txParCalc ^ txData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOut  <= 1'b0;
      lineOe   <= 1'b0;
      txShift  <= '0;
      txParBit <= 1'b0;
    end else begin
      if (strobes.loadTx) begin
        lineOe   <= 1'b1;
        lineOut  <= aligned[DATA_W-1];
        txShift  <= aligned << 1;
        txParBit <= txParCalc;
      end else if (strobes.loadRx) begin
        lineOe  <= 1'b0;
        lineOut <= 1'b0;
      end else if (strobes.txNext) begin
        lineOut <= txShift[DATA_W-1];
        txShift <= txShift << 1;
      end else if (strobes.txPar) begin
        lineOut <= txParBit;
      end else if (strobes.txEnd) begin
        lineOut <= 1'b0;  // low tail, drive enable kept
      end
    end
  end

  assign rxMismatch = rxParSeen ^ rxAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      rxAcc     <= 1'b0;
      rxParSeen <= 1'b0;
      rxData    <= '0;
      parityErr <= 1'b0;
      errCount  <= '0;
    end else begin
      if (strobes.loadRx) begin
        rxShift <= '0;
        rxAcc   <= 1'b0;
      end else if (strobes.rxBit) begin
        rxShift <= {rxShift[DATA_W-2:0], lineSync};
        rxAcc   <= rxAcc ^ lineSync;
      end else if (strobes.rxPar) begin
        rxParSeen <= lineSync;
      end else if (strobes.rxEnd) begin
        rxData    <= rxShift;
        parityErr <= rxMismatch;
        if (rxMismatch && errCount != ERR_MAX) errCount <= errCount + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= strobes.txEnd | strobes.rxEnd;
  end

endmodule

// File: rtl/swire_chunk_codec.sv
module swire_chunk_codec #(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 8,
  parameter int ERR_W    = 4,
  parameter int SYNC_LAT = 2,
  localparam int WID_W   = $clog2(DATA_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                txMode,
  input  logic [WID_W-1:0]    chunkWidth,
  input  logic [PERIOD_W-1:0] bitPeriod,
  input  logic [DATA_W-1:0]   txData,
  input  logic                lineIn,
  output logic                lineOut,
  output logic                lineOe,
  output logic [DATA_W-1:0]   rxData,
  output logic                parityErr,
  output logic [ERR_W-1:0]    errCount,
  output logic                busy,
  output logic                done
);
  swc_pkg::strobe_t strobes;
  logic [WID_W-1:0] effLen;

  swc_ctrl #(
    .DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .WID_W(WID_W), .SYNC_LAT(SYNC_LAT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .txMode(txMode),
    .chunkWidth(chunkWidth), .bitPeriod(bitPeriod),
    .strobes(strobes), .effLen(effLen), .busy(busy)
  );

  swc_dpath #(
    .DATA_W(DATA_W), .WID_W(WID_W), .ERR_W(ERR_W), .SYNC_LAT(SYNC_LAT)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .effLen(effLen),
    .txData(txData), .lineIn(lineIn), .lineOut(lineOut), .lineOe(lineOe),
    .rxData(rxData), .parityErr(parityErr), .errCount(errCount), .done(done)
  );

endmodule

// File: rtl/swc_checks.sv
module swc_checks #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineOut,
  input logic              lineOe,
  input logic [DATA_W-1:0] rxData,
  input logic              parityErr,
  input logic [ERR_W-1:0]  errCount,
  input logic              busy,
  input logic              done
);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_idle_on_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_tail_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && lineOe) |-> !lineOut);

  p_drive_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lineOe) |=> lineOe);

  p_err_monotonic_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> errCount >= $past(errCount));

  p_err_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |-> (done && parityErr && errCount == $past(errCount) + 1'b1));

  p_perr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(parityErr) && $stable(rxData)));

endmodule

bind swire_chunk_codec swc_checks #(.DATA_W(DATA_W), .ERR_W(ERR_W)) chk_i (
  .clk(clk), .rstN(rstN), .lineOut(lineOut), .lineOe(lineOe), .rxData(rxData),
  .parityErr(parityErr), .errCount(errCount), .busy(busy), .done(done)
);

// File: tb/swire_chunk_codec_tb_top.sv
module swire_chunk_codec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       start;
  logic       txMode;
  logic [3:0] chunkWidth;
  logic [7:0] bitPeriod;
  logic [7:0] txData;
  logic       benchVal;
  wire        busLine;
  logic       lineOut, lineOe, parityErr, busy, done;
  logic [7:0] rxData;
  logic [3:0] errCount;

  int checks = 0;
  int errors = 0;
  int expErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // resolved line: codec drives when enabled, else bench level (idle high)
  assign busLine = lineOe ? lineOut : benchVal;

  swire_chunk_codec dut_i (
    .clk(clk), .rstN(rstN), .start(start), .txMode(txMode),
    .chunkWidth(chunkWidth), .bitPeriod(bitPeriod), .txData(txData),
    .lineIn(busLine), .lineOut(lineOut), .lineOe(lineOe), .rxData(rxData),
    .parityErr(parityErr), .errCount(errCount), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit evenPar(input logic [7:0] d, input int w);
    bit p = 1'b0;
    for (int i = 0; i < w; i++) p ^= d[i];
    return p;
  endfunction

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic launch(input bit mode, input int reqW, input int per, input logic [7:0] d);
    txMode     = mode;
    chunkWidth = 4'(reqW);
    bitPeriod  = 8'(per);
    txData     = d;
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
    // R9: inputs changed after acceptance must not matter
    chunkWidth = 4'd3;
    bitPeriod  = 8'd13;
    txData     = ~d;
  endtask

  task automatic runTx(input int reqW, input int effW, input int per, input logic [7:0] d);
    launch(1'b1, reqW, per, d);
    for (int k = 0; k <= effW; k++) begin
      bit expBit = (k < effW) ? d[effW-1-k] : evenPar(d, effW);
      bit bad = 1'b0;
      bit seen = 1'b0;
      for (int m = 0; m < per; m++) begin
        if (k == 1 && m == 0) begin txMode = 1'b0; start = 1'b1; end  // R8 poke
        if (k == 1 && m == 1) start = 1'b0;
        if (lineOut !== expBit || lineOe !== 1'b1 || done !== 1'b0) begin
          bad = 1'b1; seen = lineOut;
        end
        @(negedge clk);
      end
      if (k < effW) check(!bad, $sformatf("R2/R8/R9 tx data cell %0d w=%0d p=%0d", k, effW, per), seen, expBit);
      else          check(!bad, $sformatf("R3 tx parity cell w=%0d p=%0d", effW, per), seen, expBit);
    end
    check(done === 1'b1 && busy === 1'b0, "R4/R10 tx done timing", {done, busy}, 2'b10);
    check(lineOe === 1'b1 && lineOut === 1'b0, "R4 tx low tail", {lineOe, lineOut}, 2'b10);
    @(negedge clk);
    check(done === 1'b0 && lineOe === 1'b1 && lineOut === 1'b0, "R4/R10 tail held, done single",
          {done, lineOe, lineOut}, 3'b010);
  endtask

  task automatic runRx(input int reqW, input int effW, input int per, input logic [7:0] d, input bit corrupt);
    int h1 = per / 2;
    bit par = evenPar(d, effW) ^ corrupt;
    logic [7:0] expD = d & 8'((1 << effW) - 1);
    launch(1'b0, reqW, per, d);
    for (int k = 0; k <= effW; k++) begin
      bit b = (k < effW) ? d[effW-1-k] : par;
      for (int m = 0; m < per; m++) begin
        // R11: correct level only in the one raw cycle that gets sampled
        benchVal = (m == h1 - 1) ? b : ~b;
        @(negedge clk);
      end
    end
    benchVal = 1'b1;
    check(done === 1'b0 && lineOe === 1'b0, "R5 rx done not early, line released", {done, lineOe}, 2'b00);
    @(negedge clk);
    check(done === 1'b0, "R5 rx done not early", done, 0);
    @(negedge clk);
    if (corrupt && expErr < 15) expErr++;
    check(done === 1'b1 && busy === 1'b0, $sformatf("R5/R10 rx done timing w=%0d p=%0d", effW, per), {done, busy}, 2'b10);
    check(rxData === expD, $sformatf("R5/R11 rx data w=%0d p=%0d", effW, per), rxData, expD);
    check(parityErr === corrupt, "R6 rx parity flag", parityErr, corrupt);
    check(errCount === 4'(expErr), "R7 error count", errCount, expErr);
    @(negedge clk);
    check(done === 1'b0 && parityErr === corrupt && rxData === expD, "R6/R10 results held after done",
          {done, parityErr}, {1'b0, corrupt});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int periods[3] = '{4, 5, 7};
    rstN = 1'b0; start = 1'b0; txMode = 1'b0; chunkWidth = 4'd8;
    bitPeriod = 8'd4; txData = 8'h00; benchVal = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({lineOut, lineOe, busy, done, parityErr} === 5'b0 && rxData === 8'h00 && errCount === 4'h0,
          "R1 reset state", {lineOut, lineOe, busy, done, parityErr}, 0);

    for (int pi = 0; pi < 3; pi++) begin
      for (int w = 1; w <= 8; w++) begin
        logic [7:0] pats[4] = '{8'h00, 8'hFF, 8'hA5, 8'(37 * w + 11 * pi)};
        for (int q = 0; q < 4; q++) runTx(w, w, periods[pi], pats[q]);
      end
    end
    runTx(0, 8, 5, 8'h3C);   // R9 width 0 taken as 8
    runTx(12, 8, 4, 8'hC3);  // R9 width above 8 taken as 8

    for (int pi = 0; pi < 3; pi++) begin
      for (int w = 1; w <= 8; w++) begin
        logic [7:0] pats[4] = '{8'h00, 8'hFF, 8'h5A, 8'(53 * w + 7 * pi)};
        for (int q = 0; q < 4; q++) begin
          for (int c = 0; c < 2; c++) runRx(w, w, periods[pi], pats[q], c[0]);
        end
      end
    end
    runRx(15, 8, 6, 8'h96, 1'b0);  // R9 out-of-range width on receive

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule